// File: doc/BRIEF.md
# I2C Command Tag Stream Generator

This block converts a single I2C message request into the sequence of command tag bytes that a tag-driven I2C master engine reads. A one-cycle `start` pulse captures the target address, the direction, the address-width and high-speed selections and the message length. The block then emits the tags for the whole message, one byte at a time, on a valid/ready byte stream.

A message longer than 256 bytes is cut into blocks of at most 256 data bytes. No STOP is placed between blocks. The START and address prefix comes only before the first block. Each block ends with a data tag and a length byte, and only the final block's data tag carries STOP.

The output follows valid/ready rules. A byte is taken on a clock edge where `tag_valid` and `tag_ready` are both high. While `tag_ready` is low, `tag_valid` and `tag_byte` keep their values, and the producer never withdraws an offered byte. After each block's length byte is accepted, the block reports how many tag bytes and how many data bytes belong to that block. It also reports the transmit-tag and receive-tag totals for the message.

Top module: `i2c_tag_gen`

## Requirements
- R1: Tag code values are START 0x81, HIGH_SPEED 0xFF, write data 0x82, write data with STOP 0x83, read data 0x85 and read data with STOP 0x87. The first byte of every message is 0x81.
- R2: Only the first block has a prefix. In normal mode the prefix is START then the address byte {addr[6:0], rd}. In high-speed mode it is START, HIGH_SPEED, START then the address. With ten-bit addressing a second address byte {5'b0, addr[9:7]} follows the first.
- R3: A message of length L has ceil(L/256) blocks. Each block is a data tag followed by a length byte. Every block except the last uses the non-STOP tag (0x82 for a write, 0x85 for a read) with length byte 0, which means 256.
- R4: The last block uses the STOP tag (0x83 for a write, 0x87 for a read). Its length byte is L mod 256, where 0 stands for 256.
- R5: In the cycle after a block's length byte is accepted, `blk_valid` pulses for one cycle. With it come `blk_tag_cnt`, the tag bytes of that block including the prefix, and `blk_data_cnt`, a value from 1 to 256.
- R6: From the cycle after an accepted start, `tx_tag_total` equals the number of tag bytes in the message. `rx_tag_total` equals 2 per block for a read and 0 for a write.
- R7: A start with length 0 produces a one-cycle `err` pulse in the following cycle and emits no tag byte.
- R8: While `tag_valid` is high and `tag_ready` is low, `tag_valid` stays high and `tag_byte` stays unchanged on the next cycle.
- R9: `done` pulses once, together with the final block's `blk_valid`, in the cycle after the final length byte is accepted. `busy` then falls.
- R10: A start pulse while `busy` is high is ignored. The stream and the totals stay those of the running message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture request fields and begin a message |
| tgt_addr | input | 10 | Target address (7-bit addresses in bits 6:0) |
| rd_req | input | 1 | 1 = read message, 0 = write message |
| ten_bit | input | 1 | Ten-bit addressing |
| hs_mode | input | 1 | High-speed prefix |
| msg_len | input | LEN_W | Message length in data bytes |
| busy | output | 1 | Message in progress |
| tag_valid | output | 1 | Tag byte offered |
| tag_ready | input | 1 | Consumer accepts tag byte |
| tag_byte | output | 8 | Tag byte |
| blk_valid | output | 1 | Per-block report strobe |
| blk_tag_cnt | output | 4 | Tag bytes in the reported block |
| blk_data_cnt | output | 9 | Data bytes in the reported block |
| tx_tag_total | output | LEN_W-6 | Total tag bytes of the message |
| rx_tag_total | output | LEN_W-6 | Receive-tag bytes of the message |
| done | output | 1 | Final block completed |
| err | output | 1 | Zero-length request rejected |

## Verification
The assertions check the behaviours that hold on every cycle. These are the hold rule under back-pressure, the START byte that opens each message, the pairing of `done` with a block report that follows a handshake, the data-count range of each report, and the silence of the output when `err` pulses. The exact byte sequence cannot be checked per cycle: prefix variants, block segmentation at 256-byte boundaries, the STOP tags on the final block, the encoding of the last length byte, and the totals all depend on the whole request. Those are shown only by the bench's scenarios. The same holds for ignoring a start while busy. Directed cases cover lengths 1, 255, 256, 257, 512 and 0, and random requests cover the remaining combinations.

// File: rtl/i2ctg_pkg.sv
package i2ctg_pkg;
  localparam logic [7:0] TG_START    = 8'h81;
  localparam logic [7:0] TG_HSPEED   = 8'hFF;
  localparam logic [7:0] TG_WR       = 8'h82;
  localparam logic [7:0] TG_WR_STOP  = 8'h83;
  localparam logic [7:0] TG_RD       = 8'h85;
  localparam logic [7:0] TG_RD_STOP  = 8'h87;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START1, ST_HS, ST_START2, ST_ADDR0, ST_ADDR1, ST_DTAG, ST_DLEN
  } tg_state_e;

  typedef struct packed {
    logic [9:0] addr;
    logic       rd;
    logic       ten;
    logic       hs;
  } tg_req_t;
endpackage

// File: rtl/i2ctg_plan.sv
// Derives block count, last-block size and tag totals from a latched request.
module i2ctg_plan
  import i2ctg_pkg::*;
#(
  parameter int LEN_W = 16,
  localparam int BLK_W = LEN_W - 7,
  localparam int TOT_W = LEN_W - 6
) (
  input  tg_req_t           req,
  input  logic [LEN_W-1:0]  len,
  output logic [BLK_W-1:0]  nblk,
  output logic [7:0]        last_len_byte,
  output logic [8:0]        last_data_cnt,
  output logic [3:0]        pre_cnt,
  output logic [TOT_W-1:0]  tx_total,
  output logic [TOT_W-1:0]  rx_total
);
  logic [TOT_W-1:0] two_per_blk;

  always_comb begin
    nblk          = BLK_W'(len[LEN_W-1:8]) + BLK_W'(|len[7:0]);
    last_len_byte = len[7:0];
    last_data_cnt = (|len[7:0]) ? {1'b0, len[7:0]} : 9'd256;
    pre_cnt       = 4'd2 + (req.hs ? 4'd2 : 4'd0) + (req.ten ? 4'd1 : 4'd0);
    two_per_blk   = {TOT_W'(nblk), 1'b0} ;
    tx_total      = two_per_blk + TOT_W'(pre_cnt);
    rx_total      = req.rd ? two_per_blk : '0;
  end
endmodule

// File: rtl/i2ctg_seq.sv
// Tag byte sequencer with valid/ready output and per-block reporting.
module i2ctg_seq
  import i2ctg_pkg::*;
#(
  parameter int LEN_W = 16,
  localparam int BLK_W = LEN_W - 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  tg_req_t           req,
  input  logic [BLK_W-1:0]  nblk,
  input  logic [7:0]        last_len_byte,
  input  logic [8:0]        last_data_cnt,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              blk_valid,
  output logic [3:0]        blk_tag_cnt,
  output logic [8:0]        blk_data_cnt,
  output logic              done
);
  tg_state_e        state_q, state_d;
  logic [BLK_W-1:0] blk_idx_q;
  logic [3:0]       blk_bytes_q;
  logic             is_last;
  logic             accept;

  assign is_last   = (blk_idx_q == nblk - BLK_W'(1));
  assign accept    = out_valid && out_ready;
  assign busy      = (state_q != ST_IDLE);
  assign out_valid = busy;

  always_comb begin
    unique case (state_q)
      ST_START1, ST_START2: out_byte = TG_START;
      ST_HS:                out_byte = TG_HSPEED;
      ST_ADDR0:             out_byte = {req.addr[6:0], req.rd};
      ST_ADDR1:             out_byte = {5'b0, req.addr[9:7]};
      ST_DTAG: begin
        if (is_last) out_byte = req.rd ? TG_RD_STOP : TG_WR_STOP;
        else         out_byte = req.rd ? TG_RD : TG_WR;
      end
      ST_DLEN:              out_byte = is_last ? last_len_byte : 8'h00;
      default:              out_byte = 8'h00;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (launch) state_d = ST_START1;
      ST_START1: if (accept) state_d = req.hs ? ST_HS : ST_ADDR0;
      ST_HS:     if (accept) state_d = ST_START2;
      ST_START2: if (accept) state_d = ST_ADDR0;
      ST_ADDR0:  if (accept) state_d = req.ten ? ST_ADDR1 : ST_DTAG;
      ST_ADDR1:  if (accept) state_d = ST_DTAG;
      ST_DTAG:   if (accept) state_d = ST_DLEN;
      ST_DLEN:   if (accept) state_d = is_last ? ST_IDLE : ST_DTAG;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      blk_idx_q    <= '0;
      blk_bytes_q  <= '0;
      blk_valid    <= 1'b0;
      blk_tag_cnt  <= '0;
      blk_data_cnt <= '0;
      done         <= 1'b0;
    end else begin
      state_q   <= state_d;
      blk_valid <= 1'b0;
      done      <= 1'b0;
      if (state_q == ST_IDLE && launch) begin
        blk_idx_q   <= '0;
        blk_bytes_q <= '0;
      end else if (accept) begin
        if (state_q == ST_DLEN) begin
          blk_valid    <= 1'b1;
          blk_tag_cnt  <= blk_bytes_q + 4'd1;
          blk_data_cnt <= is_last ? last_data_cnt : 9'd256;
          done         <= is_last;
          blk_bytes_q  <= '0;
          blk_idx_q    <= blk_idx_q + BLK_W'(1);
        end else begin
          blk_bytes_q <= blk_bytes_q + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_tag_gen.sv
module i2c_tag_gen
  import i2ctg_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [9:0]         tgt_addr,
  input  logic               rd_req,
  input  logic               ten_bit,
  input  logic               hs_mode,
  input  logic [LEN_W-1:0]   msg_len,
  output logic               busy,
  output logic               tag_valid,
  input  logic               tag_ready,
  output logic [7:0]         tag_byte,
  output logic               blk_valid,
  output logic [3:0]         blk_tag_cnt,
  output logic [8:0]         blk_data_cnt,
  output logic [LEN_W-7:0]   tx_tag_total,
  output logic [LEN_W-7:0]   rx_tag_total,
  output logic               done,
  output logic               err
);
  localparam int BLK_W = LEN_W - 7;

  tg_req_t          req_q;
  logic [LEN_W-1:0] len_q;
  logic             take, launch;
  logic [BLK_W-1:0] nblk;
  logic [7:0]       last_len_byte;
  logic [8:0]       last_data_cnt;
  logic [3:0]       pre_cnt;

  assign take   = start && !busy;
  assign launch = take && (msg_len != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      len_q <= '0;
      err   <= 1'b0;
    end else begin
      err <= take && (msg_len == '0);
      if (launch) begin
        req_q <= '{addr: tgt_addr, rd: rd_req, ten: ten_bit, hs: hs_mode};
        len_q <= msg_len;
      end
    end
  end

  i2ctg_plan #(.LEN_W(LEN_W)) plan_i (
    .req(req_q), .len(len_q), .nblk(nblk), .last_len_byte(last_len_byte),
    .last_data_cnt(last_data_cnt), .pre_cnt(pre_cnt),
    .tx_total(tx_tag_total), .rx_total(rx_tag_total)
  );

  i2ctg_seq #(.LEN_W(LEN_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .req(req_q), .nblk(nblk),
    .last_len_byte(last_len_byte), .last_data_cnt(last_data_cnt),
    .busy(busy), .out_valid(tag_valid), .out_ready(tag_ready),
    .out_byte(tag_byte), .blk_valid(blk_valid), .blk_tag_cnt(blk_tag_cnt),
    .blk_data_cnt(blk_data_cnt), .done(done)
  );
endmodule

// File: rtl/i2ctg_chk.sv
module i2ctg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       tag_valid,
  input logic       tag_ready,
  input logic [7:0] tag_byte,
  input logic       blk_valid,
  input logic [8:0] blk_data_cnt,
  input logic       done,
  input logic       err
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid && !tag_ready |=> tag_valid && $stable(tag_byte));

  p_open_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tag_valid) |-> tag_byte == 8'h81);

  p_done_with_blk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> blk_valid && !busy);

  p_blk_after_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> $past(tag_valid && tag_ready));

  p_blk_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> (blk_data_cnt != 9'd0) && (blk_data_cnt <= 9'd256));

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !tag_valid && !busy);
endmodule

bind i2c_tag_gen i2ctg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tag_valid(tag_valid),
  .tag_ready(tag_ready), .tag_byte(tag_byte), .blk_valid(blk_valid),
  .blk_data_cnt(blk_data_cnt), .done(done), .err(err)
);

// File: tb/i2c_tag_gen_tb_top.sv
module i2c_tag_gen_tb_top;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rd_req = 1'b0, ten_bit = 1'b0, hs_mode = 1'b0;
  logic [9:0] tgt_addr = '0;
  logic [LEN_W-1:0] msg_len = '0;
  logic tag_ready = 1'b0;
  logic busy, tag_valid, blk_valid, done, err;
  logic [7:0] tag_byte;
  logic [3:0] blk_tag_cnt;
  logic [8:0] blk_data_cnt;
  logic [LEN_W-7:0] tx_tag_total, rx_tag_total;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_b [0:1023];
  int exp_n, exp_blks, exp_pre;

  always #2 clk = ~clk;

  i2c_tag_gen #(.LEN_W(LEN_W)) dut_i (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic build(input logic [9:0] a, input bit rd, input bit ten,
                       input bit hs, input int len);
    int k = 0;
    exp_blks = (len + 255) / 256;
    exp_b[k++] = 8'h81;
    if (hs) begin exp_b[k++] = 8'hFF; exp_b[k++] = 8'h81; end
    exp_b[k++] = {a[6:0], rd};
    if (ten) exp_b[k++] = {5'b0, a[9:7]};
    exp_pre = k;
    for (int b = 0; b < exp_blks; b++) begin
      if (b == exp_blks - 1) begin
        exp_b[k++] = rd ? 8'h87 : 8'h83;
        exp_b[k++] = 8'(len % 256);
      end else begin
        exp_b[k++] = rd ? 8'h85 : 8'h82;
        exp_b[k++] = 8'h00;
      end
    end
    exp_n = k;
  endtask

  task automatic run_msg(input logic [9:0] a, input bit rd, input bit ten,
                         input bit hs, input int len, input int rdy_pct,
                         input bit inject);
    int idx = 0, blk = 0, cyc = 0;
    bit held = 0, fin = 0;
    logic [7:0] hb = '0;
    build(a, rd, ten, hs, len);
    @(negedge clk);
    tgt_addr = a; rd_req = rd; ten_bit = ten; hs_mode = hs;
    msg_len = LEN_W'(len); start = 1'b1; tag_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    // R6: totals registered from the cycle after start
    chk(int'(tx_tag_total) == exp_n, "R6 tx_total", int'(tx_tag_total), exp_n);
    chk(int'(rx_tag_total) == (rd ? 2*exp_blks : 0), "R6 rx_total",
        int'(rx_tag_total), rd ? 2*exp_blks : 0);
    while (!fin && cyc < 5000) begin
      if (blk_valid) begin
        int et = (blk == 0) ? exp_pre + 2 : 2;
        int ed = (blk < exp_blks - 1) ? 256 : ((len % 256) == 0 ? 256 : len % 256);
        chk(int'(blk_tag_cnt) == et, "R5 blk_tag_cnt", int'(blk_tag_cnt), et);
        chk(int'(blk_data_cnt) == ed, "R5 blk_data_cnt", int'(blk_data_cnt), ed);
        chk(done == (blk == exp_blks - 1), "R9 done with last block", done,
            blk == exp_blks - 1);
        blk++;
      end else begin
        chk(!done, "R9 done only with block report", done, 0);
      end
      if (done) begin
        fin = 1;
        chk(!busy && !tag_valid, "R9 idle after done", busy, 0);
        chk(blk == exp_blks, "R3 block count", blk, exp_blks);
        chk(idx == exp_n, "R3 byte count", idx, exp_n);
        break;
      end
      if (held) begin
        chk(tag_valid && tag_byte == hb, "R8 hold under back-pressure",
            tag_byte, hb);
      end
      start = 1'b0;
      if (inject && idx == 2) begin
        // R10: start while busy with other fields must be ignored
        start = 1'b1; tgt_addr = ~a; rd_req = ~rd; msg_len = LEN_W'(3);
        hs_mode = ~hs;
      end
      tag_ready = (($urandom % 100) < rdy_pct);
      held = tag_valid && !tag_ready;
      hb = tag_byte;
      if (tag_valid && tag_ready) begin
        if (idx < exp_n)
          chk(tag_byte == exp_b[idx], "R1 R2 R3 R4 R10 tag byte", tag_byte,
              exp_b[idx]);
        else
          chk(0, "R3 extra byte", tag_byte, -1);
        idx++;
      end
      @(negedge clk);
      cyc++;
      if (inject) begin
        chk(int'(tx_tag_total) == exp_n, "R10 totals unchanged",
            int'(tx_tag_total), exp_n);
      end
    end
    start = 1'b0;
    tag_ready = 1'b0;
    if (!fin) chk(0, "watchdog message end", cyc, -1);
  endtask

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!tag_valid && !busy && !done && !err && !blk_valid, "R9 reset state",
        tag_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed corners
    run_msg(10'h050, 0, 0, 0, 1, 100, 0);
    run_msg(10'h2A5, 1, 1, 1, 255, 60, 0);
    run_msg(10'h013, 0, 0, 1, 256, 70, 0);
    run_msg(10'h3FF, 1, 0, 0, 257, 50, 0);
    run_msg(10'h155, 0, 1, 0, 512, 80, 0);
    run_msg(10'h071, 1, 0, 1, 600, 40, 1);
    // R7: zero length
    @(negedge clk);
    msg_len = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R7 err pulse", err, 1);
    chk(!tag_valid && !busy, "R7 no tags", tag_valid, 0);
    @(negedge clk);
    chk(err == 1'b0 && !tag_valid, "R7 single pulse", err, 0);
    // Random requests
    for (int i = 0; i < 40; i++) begin
      run_msg(10'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1 + int'($urandom % 800), 30 + int'($urandom % 71), 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule